// File: doc/BRIEF.md
# Conversion Result Register Pair

This block stores the 10-bit result of an analog-to-digital conversion and shows it to a processor bus as two 8-bit read-only registers: a low byte and a high byte. A strobe marks the end of each conversion and brings in the new value. A read strobe with a byte address returns one of the two views in the same cycle.

Reading the low byte locks the pair. While the pair is locked, no new conversion may overwrite it. Reading the high byte releases the lock. Software that reads low then high is therefore sure that both bytes come from one conversion. A conversion strobe that arrives while the pair is locked is discarded, and a sticky flag records the loss.

A left-adjust control moves the result to the top of the 16-bit pair. In that mode the high byte alone gives an 8-bit reading. Both views are built combinationally from one stored value, so a change of the control shows on the next read.

Top module: `adc_result_pair`

## Requirements
- R1: When `convDone` is high, the pair is unlocked and no low-byte read happens in that cycle, `convData` is stored at that clock edge. It is visible to reads from the next cycle.
- R2: A read at `LO_ADDR` locks the pair from the next edge. While the pair is locked and no high-byte read happens, `convDone` changes nothing stored.
- R3: A read at `HI_ADDR` clears the lock at that edge. If `convDone` is high in the same cycle, the read returns the old data and the new value is stored at that edge.
- R4: With `leftAdj`=0, the high byte is {6'b0, value[9:8]} and the low byte is value[7:0].
- R5: With `leftAdj`=1, the high byte is value[9:2] and the low byte is {value[1:0], 6'b0}.
- R6: A change of `leftAdj` alters the next read with no new conversion.
- R7: A synchronous active-high `rst` clears the stored value to 0, the lock and `dropped`. After reset both bytes read 0x00.
- R8: A high-byte read while the pair is unlocked returns current data and leaves the pair unlocked, so a following `convDone` is stored.
- R9: `dropped` goes high at the edge after a discarded `convDone` and stays high until reset.
- R10: A `convDone` in the same cycle as a low-byte read is discarded. The low byte read and the later high byte come from the older value.
- R11: `rdData` is 0x00 when `rdStrobe` is low or `rdAddr` matches neither byte. Such cycles do not change the lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| convDone | input | 1 | Conversion-complete strobe |
| convData | input | 10 | Result accompanying `convDone` |
| leftAdj | input | 1 | 1 selects the left-adjusted byte layout |
| rdStrobe | input | 1 | Byte read strobe |
| rdAddr | input | 8 | Byte address of the read |
| rdData | output | 8 | Read data, combinational |
| dropped | output | 1 | Sticky flag: a conversion was discarded |

## Verification
The pair is tried with several read orders: low then high, high alone, repeated high reads, and reads at unrelated addresses. These tell a working lock apart from one that never sets or never clears. Conversion strobes are placed in four cycles relative to the reads: before the low read, on the low read, between the two reads, and on the high read. These separate the capture gating at each boundary. Both layouts are read from a single stored value, with the control flipped between reads. After that, a long random phase mixes all inputs against a behavioural model.

// File: rtl/adc_pair_pkg.sv
package adc_pair_pkg;
  // Strobes from the control to the datapath
  typedef struct packed {
    logic capture;  // store convData at this edge
    logic readLo;   // low byte addressed this cycle
    logic readHi;   // high byte addressed this cycle
  } pairCtrl_t;
endpackage

// File: rtl/adc_pair_ctrl.sv
module adc_pair_ctrl
  import adc_pair_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int LO_ADDR = 4,
  parameter int HI_ADDR = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              convDone,
  input  logic              rdStrobe,
  input  logic [ADDR_W-1:0] rdAddr,
  output pairCtrl_t         ctrl,
  output logic              locked,
  output logic              dropped
);
  localparam logic [ADDR_W-1:0] LoA = ADDR_W'(LO_ADDR);
  localparam logic [ADDR_W-1:0] HiA = ADDR_W'(HI_ADDR);

  logic readLo, readHi, capture;

  always_comb begin
    readLo  = rdStrobe && (rdAddr == LoA);
    readHi  = rdStrobe && (rdAddr == HiA);
    // a high read frees the pair at this edge; a low read freezes old data
    capture = convDone && (!locked || readHi) && !readLo;
    ctrl.capture = capture;
    ctrl.readLo  = readLo;
    ctrl.readHi  = readHi;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      locked  <= 1'b0;
      dropped <= 1'b0;
    end else begin
      if (readLo)      locked <= 1'b1;
      else if (readHi) locked <= 1'b0;
      if (convDone && !capture) dropped <= 1'b1;
    end
  end

  p_reset_clear_r7: assert property (@(posedge clk) rst |=> (!locked && !dropped));
  p_lowread_locks_r2: assert property (@(posedge clk) disable iff (rst)
    (rdStrobe && rdAddr == LoA) |=> locked);
  p_highread_frees_r3: assert property (@(posedge clk) disable iff (rst)
    (rdStrobe && rdAddr == HiA) |=> !locked);
  p_high_no_lock_r8: assert property (@(posedge clk) disable iff (rst)
    (!locked && rdStrobe && rdAddr == HiA) |=> !locked);
  p_drop_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    dropped |=> dropped);
  p_other_addr_r11: assert property (@(posedge clk) disable iff (rst)
    (!rdStrobe || (rdAddr != LoA && rdAddr != HiA)) |=> (locked == $past(locked)));
endmodule

// File: rtl/adc_pair_dp.sv
module adc_pair_dp
  import adc_pair_pkg::*;
#(
  parameter int RES_W  = 10,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  pairCtrl_t         ctrl,
  input  logic [RES_W-1:0]  convData,
  input  logic              leftAdj,
  output logic [BYTE_W-1:0] rdData,
  output logic [RES_W-1:0]  storedVal
);
  localparam int WORD_W  = 2 * BYTE_W;
  localparam int LEFT_SH = WORD_W - RES_W;
  localparam int HI_USED = RES_W - BYTE_W;

  logic [WORD_W-1:0] rightWord, leftWord, viewWord;
  logic [BYTE_W-1:0] loView, hiView;

  always_ff @(posedge clk) begin
    if (rst)               storedVal <= '0;
    else if (ctrl.capture) storedVal <= convData;
  end

  always_comb begin
    rightWord = WORD_W'(storedVal);
    leftWord  = rightWord << LEFT_SH;
    viewWord  = leftAdj ? leftWord : rightWord;
    loView    = viewWord[BYTE_W-1:0];
    hiView    = viewWord[WORD_W-1:BYTE_W];
    if (ctrl.readLo)      rdData = loView;
    else if (ctrl.readHi) rdData = hiView;
    else                  rdData = '0;
  end

  p_right_hi_zero_r4: assert property (@(posedge clk) disable iff (rst)
    !leftAdj |-> (hiView[BYTE_W-1:HI_USED] == '0));
  p_left_lo_zero_r5: assert property (@(posedge clk) disable iff (rst)
    leftAdj |-> (loView[LEFT_SH-1:0] == '0));
  p_idle_zero_r11: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.readLo && !ctrl.readHi) |-> (rdData == '0));
endmodule

// File: rtl/adc_result_pair.sv
module adc_result_pair
  import adc_pair_pkg::*;
#(
  parameter int RES_W   = 10,
  parameter int BYTE_W  = 8,
  parameter int ADDR_W  = 8,
  parameter int LO_ADDR = 4,
  parameter int HI_ADDR = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              convDone,
  input  logic [RES_W-1:0]  convData,
  input  logic              leftAdj,
  input  logic              rdStrobe,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [BYTE_W-1:0] rdData,
  output logic              dropped
);
  pairCtrl_t        ctrl;
  logic             locked;
  logic [RES_W-1:0] storedVal;

  adc_pair_ctrl #(.ADDR_W(ADDR_W), .LO_ADDR(LO_ADDR), .HI_ADDR(HI_ADDR)) u_ctrl (
    .clk(clk), .rst(rst), .convDone(convDone), .rdStrobe(rdStrobe),
    .rdAddr(rdAddr), .ctrl(ctrl), .locked(locked), .dropped(dropped)
  );

  adc_pair_dp #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_dp (
    .clk(clk), .rst(rst), .ctrl(ctrl), .convData(convData),
    .leftAdj(leftAdj), .rdData(rdData), .storedVal(storedVal)
  );

  p_capture_r1: assert property (@(posedge clk) disable iff (rst)
    (convDone && !locked && !(rdStrobe && rdAddr == ADDR_W'(LO_ADDR)))
      |=> (storedVal == $past(convData)));
  p_hold_locked_r2: assert property (@(posedge clk) disable iff (rst)
    (locked && !(rdStrobe && rdAddr == ADDR_W'(HI_ADDR))) |=> $stable(storedVal));
  p_high_release_capture_r3: assert property (@(posedge clk) disable iff (rst)
    (locked && convDone && rdStrobe && rdAddr == ADDR_W'(HI_ADDR))
      |=> (storedVal == $past(convData)));
  p_lo_conflict_r10: assert property (@(posedge clk) disable iff (rst)
    (convDone && rdStrobe && rdAddr == ADDR_W'(LO_ADDR)) |=> ($stable(storedVal) && dropped));
endmodule

// File: tb/tb_adc_result_pair.sv
`timescale 1ns/100ps
module tb_adc_result_pair;
  localparam int LO = 4, HI = 5, OTHER = 9;

  logic       clk = 1'b0, rst = 1'b1, convDone = 1'b0, leftAdj = 1'b0, rdStrobe = 1'b0;
  logic [9:0] convData = '0;
  logic [7:0] rdAddr = '0, rdData;
  logic       dropped;

  int errors = 0, checks = 0, cyc = 0;
  bit done = 0;
  int refVal = 0; bit refLock = 0, refDrop = 0;

  always #2.5 clk = ~clk;

  adc_result_pair dut (.clk(clk), .rst(rst), .convDone(convDone), .convData(convData),
    .leftAdj(leftAdj), .rdStrobe(rdStrobe), .rdAddr(rdAddr), .rdData(rdData), .dropped(dropped));

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s cycle %0d: actual=%0h expected=%0h", tag, cyc, act, exp);
    end
  endtask

  function automatic int expRead(bit rd, int addr, bit adj);
    if (!rd) return 0;
    if (addr == LO) return adj ? (refVal % 4) * 64 : refVal % 256;
    if (addr == HI) return adj ? refVal / 4 : refVal / 256;
    return 0;
  endfunction

  // one bus cycle: drive at negedge, check read, then model the edge
  task automatic step(string tag, bit cd, int data, bit adj, bit rd, int addr);
    bit lowR, hiR, cap;
    @(negedge clk);
    convDone = cd; convData = 10'(data); leftAdj = adj; rdStrobe = rd; rdAddr = 8'(addr);
    #1;
    check(tag, rdData, expRead(rd, addr, adj));
    lowR = rd && addr == LO; hiR = rd && addr == HI;
    cap = cd && (!refLock || hiR) && !lowR;
    @(posedge clk); cyc++;
    if (cap) refVal = data; else if (cd) refDrop = 1;
    if (lowR) refLock = 1; else if (hiR) refLock = 0;
    #1;
    check("R9", dropped, refDrop);
  endtask

  task automatic doReset();
    @(negedge clk); rst = 1; convDone = 0; rdStrobe = 0;
    @(posedge clk); #1; rst = 0;
    refVal = 0; refLock = 0; refDrop = 0;
  endtask

  initial begin
    while (!done && cyc < 150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    doReset();
    // R7: reset state
    step("R7", 0, 0, 0, 1, LO);
    step("R7", 0, 0, 0, 1, HI);
    check("R7", dropped, 0);
    doReset();
    // R1/R4: capture and right-adjusted layout
    step("R1", 1, 'h2A5, 0, 0, 0);
    step("R4", 0, 0, 0, 1, LO);           // locks
    step("R2", 1, 'h111, 0, 0, 0);        // discarded
    step("R2", 0, 0, 0, 1, HI);           // 0x02
    step("R2", 0, 0, 0, 1, LO);
    step("R4", 0, 0, 0, 1, HI);
    // R5/R6: left layout from the same stored value
    step("R5", 0, 0, 1, 1, HI);
    step("R6", 0, 0, 1, 1, LO);
    step("R6", 0, 0, 0, 1, HI);           // releases lock
    // R8: high read alone keeps pair unlocked
    doReset();
    step("R8", 0, 0, 0, 1, HI);
    step("R8", 1, 'h3C7, 0, 0, 0);
    step("R8", 0, 0, 1, 1, HI);
    // R3: high read with simultaneous conversion
    step("R3", 0, 0, 0, 1, LO);
    step("R3", 1, 'h155, 0, 1, HI);
    step("R3", 0, 0, 0, 1, LO);
    step("R3", 0, 0, 0, 1, HI);
    // R10: conversion on the low read cycle
    step("R10", 1, 'h0FF, 0, 1, LO);
    step("R10", 0, 0, 0, 1, HI);
    // R11: unrelated address and idle reads
    step("R11", 0, 0, 0, 1, OTHER);
    step("R11", 1, 'h201, 0, 0, LO);
    step("R11", 0, 0, 0, 1, HI);
    step("R11", 0, 0, 1, 1, LO);
    step("R11", 0, 0, 1, 1, HI);
    // random mix against the model
    doReset();
    for (int i = 0; i < 3000; i++) begin
      int sel = $urandom_range(0, 3);
      step("R1", $urandom_range(0, 2) == 0, $urandom_range(0, 1023), $urandom_range(0, 1),
           $urandom_range(0, 3) != 0, sel == 0 ? LO : sel == 1 ? HI : sel == 2 ? OTHER : LO);
      if (i == 1500) doReset();
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule